// File: doc/BRIEF.md
# Paced Serial Command Sender

This block issues two-character commands to a battery-powered time receiver attached through a slow asynchronous serial line. The receiver draws the power for its own transmitter from the host's lines. It therefore returns every character it gets as an echo, and it cannot take the next character until that echo has gone out and a short settling interval has passed. The block accepts a two-bit command code on a valid/ready port. It turns the code into the matching command letter, appends a carriage return, and hands each byte in turn to an external byte serializer.

After each byte leaves, the block waits for the same byte to come back on the receive-byte interface. It then counts a guard interval before it releases the next byte. A wrong echo aborts the command with an error pulse. An echo that never arrives aborts it with a timeout pulse. A clean completion produces a one-cycle done pulse. Character timing is worked out from the system clock frequency, the baud rate and the frame format (one start bit, data bits, stop bits). The echo timeout is programmed as a number of character times.

Top module: `serial_cmd_pacer`

## Requirements
- R1: After reset, and whenever reset is asserted in the middle of a command, busy is 0, cmd_ready is 1, tx_valid is 0, and done, timeout and echo_err are 0.
- R2: Command code 0 sends byte 0x67, code 1 sends 0x68 and code 2 sends 0x6F. Each of these letters is followed by a carriage return, 0x0D, as the second and last byte.
- R3: Once tx_valid is high, it stays high and tx_data stays unchanged until a cycle in which tx_ready is high.
- R4: After a byte has been handed over, tx_valid stays low until a received byte equal to that byte has been seen.
- R5: After a matching echo, tx_valid and done stay low for at least GUARD_CYCLES = CLK_HZ*GUARD_US/1e6 clock cycles.
- R6: If the first received byte while waiting for an echo differs from the byte sent, echo_err pulses for one cycle and the block returns to idle without sending another byte.
- R7: If no byte is received within timeout_chars*CHAR_CYCLES cycles after hand-over, timeout pulses for one cycle and the block returns to idle. CHAR_CYCLES = (CLK_HZ/BAUD)*(1+DATA_BITS+STOP_BITS).
- R8: A command is accepted only while idle. While busy, cmd_ready is 0, and a request presented then has no effect on the bytes being sent.
- R9: done pulses for exactly one cycle once the carriage-return echo and its guard interval have both completed. At most one of done, timeout and echo_err is high in any cycle.
- R10: Code 3 is reserved. It is accepted, produces a one-cycle echo_err pulse, and sends no byte.
- R11: Bytes received while the block is idle or counting a guard interval are ignored and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_code | input | 2 | 0 signal quality, 1 resync, 2 timestamp, 3 reserved |
| cmd_ready | output | 1 | High while idle; request taken when both are high |
| timeout_chars | input | TMO_W | Echo timeout in character times |
| tx_data | output | 8 | Byte to the serializer |
| tx_valid | output | 1 | tx_data is offered |
| tx_ready | input | 1 | Serializer takes the byte |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| timeout | output | 1 | One-cycle pulse when an echo is missing |
| echo_err | output | 1 | One-cycle pulse on a wrong echo or a reserved code |

## Verification
The bench holds tx_ready low for several cycles to catch a byte that changes or disappears before hand-over. It watches the line between hand-over and echo, and throughout the guard interval, to catch a design that sends the carriage return too early. A stray byte is injected during the guard interval and a wrong echo is injected in the echo window; a design that compared echoes at the wrong time would then report a false error or miss a real one. The timeout run measures the time to the pulse, so a counter loaded with the wrong width or product fires early. Requests made while busy and a reset in the middle of a command are used to expose a design that overwrites the letter in progress or stays stuck busy.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  typedef enum logic [1:0] {
    CMD_QUALITY = 2'd0,
    CMD_RESYNC  = 2'd1,
    CMD_STAMP   = 2'd2,
    CMD_RSVD    = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_SEND  = 2'd1,
    S_ECHO  = 2'd2,
    S_GUARD = 2'd3
  } state_e;

  localparam logic [7:0] CH_CR = 8'h0D;

  // Letter for each command; the receiver decodes only the low nibble.
  function automatic logic [7:0] cmd_letter(input cmd_e c);
    case (c)
      CMD_QUALITY: cmd_letter = 8'h67;
      CMD_RESYNC:  cmd_letter = 8'h68;
      CMD_STAMP:   cmd_letter = 8'h6F;
      default:     cmd_letter = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/pace_timer.sv
module pace_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/echo_watch.sv
module echo_watch #(
  parameter int DW = 8
) (
  input  logic          armed,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic [DW-1:0] sent,
  output logic          hit,
  output logic          miss
);
  logic seen;
  assign seen = armed && rx_valid;
  assign hit  = seen && (rx_data == sent);
  assign miss = seen && (rx_data != sent);
endmodule

// File: rtl/serial_cmd_pacer.sv
module serial_cmd_pacer
  import pacer_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int BAUD      = 300,
  parameter int DATA_BITS = 8,
  parameter int STOP_BITS = 2,
  parameter int GUARD_US  = 10_000,
  parameter int TMO_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_code,
  output logic             cmd_ready,
  input  logic [TMO_W-1:0] timeout_chars,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             busy,
  output logic             done,
  output logic             timeout,
  output logic             echo_err
);
  localparam longint BIT_CYC   = longint'(CLK_HZ) / longint'(BAUD);
  localparam longint CHAR_CYC  = BIT_CYC * longint'(1 + DATA_BITS + STOP_BITS);
  localparam longint GUARD_CYC = (longint'(CLK_HZ) * longint'(GUARD_US)) / 64'd1_000_000;
  localparam longint TMO_MAX   = CHAR_CYC * ((longint'(1) << TMO_W) - 1);
  localparam longint CNT_MAX   = (TMO_MAX > GUARD_CYC) ? TMO_MAX : GUARD_CYC;
  localparam int     CNT_W     = $clog2(CNT_MAX + 1);

  state_e          state;
  logic            second;
  logic [7:0]      tx_q;
  logic            done_q, tmo_q, err_q;
  logic            hit, miss, tmr_zero, tmr_load;
  logic [CNT_W-1:0] tmr_val, tmo_load;

  assign tmo_load = CNT_W'(timeout_chars) * CNT_W'(CHAR_CYC);
  assign tmr_load = (state == S_SEND && tx_ready) || hit;
  assign tmr_val  = hit ? CNT_W'(GUARD_CYC) : tmo_load;

  pace_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  echo_watch #(.DW(8)) u_echo (
    .armed    (state == S_ECHO),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .sent     (tx_q),
    .hit      (hit),
    .miss     (miss)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      second <= 1'b0;
      tx_q   <= '0;
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      err_q  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cmd_valid) begin
            if (cmd_e'(cmd_code) == CMD_RSVD) begin
              err_q <= 1'b1;
            end else begin
              tx_q   <= cmd_letter(cmd_e'(cmd_code));
              second <= 1'b0;
              state  <= S_SEND;
            end
          end
        end
        S_SEND: begin
          if (tx_ready) state <= S_ECHO;
        end
        S_ECHO: begin
          if (hit) begin
            state <= S_GUARD;
          end else if (miss) begin
            err_q <= 1'b1;
            state <= S_IDLE;
          end else if (tmr_zero) begin
            tmo_q <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_GUARD: begin
          if (tmr_zero) begin
            if (second) begin
              done_q <= 1'b1;
              state  <= S_IDLE;
            end else begin
              tx_q   <= CH_CR;
              second <= 1'b1;
              state  <= S_SEND;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);
  assign tx_valid  = (state == S_SEND);
  assign tx_data   = tx_q;
  assign done      = done_q;
  assign timeout   = tmo_q;
  assign echo_err  = err_q;
endmodule

// File: rtl/pacer_checker.sv
module pacer_checker (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       busy,
  input logic       done,
  input logic       timeout,
  input logic       echo_err
);
  // R3: an offered byte is held until taken
  a_r3_tx_hold: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R4: no back-to-back bytes without an echo in between
  a_r4_no_burst: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_ready |=> !tx_valid);

  // R9: completion indications are exclusive
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, timeout, echo_err}));

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: an accepted request starts work or is rejected as reserved
  a_r8_accept: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready |=> busy || echo_err);

  // R6: after an error nothing is sent
  a_r6_err_quiet: assert property (@(posedge clk) disable iff (rst)
    echo_err |-> !tx_valid && !busy);
endmodule

bind serial_cmd_pacer pacer_checker u_pacer_checker (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .tx_data   (tx_data),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .busy      (busy),
  .done      (done),
  .timeout   (timeout),
  .echo_err  (echo_err)
);

// File: tb/tb_serial_cmd_pacer.sv
`timescale 1ns/1ps
module tb_serial_cmd_pacer;
  localparam int CLK_HZ   = 3000;
  localparam int BAUD     = 300;
  localparam int GUARD    = 30;           // 3000 * 10000 / 1e6
  localparam int CHAR_CYC = 110;          // 10 * 11
  localparam int TMO_CH   = 2;
  localparam int TMO_CYC  = TMO_CH * CHAR_CYC;
  localparam logic [1:0] RES_DONE = 2'd0, RES_ERR = 2'd1, RES_TMO = 2'd2;
  localparam int NVEC = 8;
  // {code, letter echo mode, CR echo mode, result}; mode 0 good, 1 wrong, 2 none
  localparam logic [7:0] VEC [NVEC] = '{
    {2'd0, 2'd0, 2'd0, RES_DONE},
    {2'd1, 2'd0, 2'd0, RES_DONE},
    {2'd2, 2'd0, 2'd0, RES_DONE},
    {2'd0, 2'd1, 2'd0, RES_ERR},
    {2'd2, 2'd0, 2'd1, RES_ERR},
    {2'd1, 2'd2, 2'd0, RES_TMO},
    {2'd0, 2'd0, 2'd2, RES_TMO},
    {2'd3, 2'd0, 2'd0, RES_ERR}
  };

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, tx_ready = 0, rx_valid = 0;
  logic [1:0] cmd_code = 0;
  logic [7:0] rx_data = 0;
  logic [1:0] timeout_chars = TMO_CH[1:0];
  logic [3:0] tmo_in;
  logic cmd_ready, tx_valid, busy, done, timeout, echo_err;
  logic [7:0] tx_data;
  int checks = 0, errors = 0, tick = 0, hs_tick = 0;
  logic poke_busy = 0;

  assign tmo_in = {2'b00, timeout_chars};
  always #2 clk = ~clk;
  always @(negedge clk) tick++;

  serial_cmd_pacer #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_ready(cmd_ready), .timeout_chars(tmo_in), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .busy(busy), .done(done), .timeout(timeout),
    .echo_err(echo_err));

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] letter_of(input logic [1:0] c);
    case (c)
      2'd0: return 8'h67;
      2'd1: return 8'h68;
      default: return 8'h6F;
    endcase
  endfunction

  task automatic send_cmd(input logic [1:0] c);
    @(negedge clk);
    check(cmd_ready == 1'b1, "R8 ready when idle", int'(cmd_ready), 1);
    cmd_valid = 1; cmd_code = c;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic do_char(input logic [7:0] b, input logic [1:0] mode);
    int w = 0;
    logic bad = 0;
    while (!tx_valid && w < 60) begin @(negedge clk); w++; end
    check(tx_valid == 1'b1, "R2 byte offered", int'(tx_valid), 1);
    check(tx_data == b, "R2 byte value", int'(tx_data), int'(b));
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      if (!tx_valid || tx_data != b) bad = 1;
    end
    check(!bad, "R3 held until ready", int'(tx_data), int'(b));
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
    hs_tick = tick;
    bad = 0;
    for (int k = 0; k < 5; k++) begin
      if (poke_busy) begin
        cmd_valid = 1; cmd_code = 2'd2;
        if (cmd_ready || !busy) bad = 1;
      end
      @(negedge clk);
      if (tx_valid) bad = 1;
    end
    cmd_valid = 0;
    check(!bad, "R4 R8 quiet before echo", int'(tx_valid), 0);
    if (mode == 2'd0) begin
      rx_valid = 1; rx_data = b;
      @(negedge clk);
      rx_valid = 0;
      bad = 0;
      for (int k = 0; k < GUARD; k++) begin
        if (k == 3) begin rx_valid = 1; rx_data = ~b; end
        if (k == 4) rx_valid = 0;
        @(negedge clk);
        if (tx_valid || done || echo_err) bad = 1;
      end
      check(!bad, "R5 R11 guard interval", int'(tx_valid), 0);
    end else if (mode == 2'd1) begin
      rx_valid = 1; rx_data = b ^ 8'h01;
      @(negedge clk);
      rx_valid = 0;
    end
  endtask

  task automatic wait_result(input logic [1:0] exp, input string req);
    int w = 0;
    logic [1:0] got = 2'd3;
    while (!(done || timeout || echo_err) && w < 400) begin @(negedge clk); w++; end
    if (done) got = RES_DONE;
    else if (echo_err) got = RES_ERR;
    else if (timeout) got = RES_TMO;
    check(got == exp, req, int'(got), int'(exp));
    if (got == RES_TMO)
      check((tick - hs_tick) >= TMO_CYC && (tick - hs_tick) <= TMO_CYC + 4,
            "R7 timeout delay", tick - hs_tick, TMO_CYC + 1);
    @(negedge clk);
    check(!done && !timeout && !echo_err && !busy,
          "R9 single pulse, idle after", int'({done, timeout, echo_err, busy}), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (tx_valid) check(0, "R6 nothing sent after end", 1, 0);
    end
  endtask

  task automatic run_row(input logic [7:0] v);
    logic [1:0] c = v[7:6];
    send_cmd(c);
    if (c != 2'd3) begin
      do_char(letter_of(c), v[5:4]);
      if (v[5:4] == 2'd0) do_char(8'h0D, v[3:2]);
    end
    wait_result(v[1:0], c == 2'd3 ? "R10 reserved code" :
                v[1:0] == RES_DONE ? "R9 done" :
                v[1:0] == RES_ERR ? "R6 wrong echo" : "R7 missing echo");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && cmd_ready && !tx_valid && !done && !timeout && !echo_err,
          "R1 reset state", int'({busy, cmd_ready, tx_valid}), 3'b010);
    rst = 0;
    // R11: stray byte while idle
    @(negedge clk); rx_valid = 1; rx_data = 8'h55;
    @(negedge clk); rx_valid = 0;
    @(negedge clk);
    check(!busy && !echo_err && !tx_valid, "R11 idle ignores rx", int'(busy), 0);
    for (int i = 0; i < NVEC; i++) run_row(VEC[i]);
    // R8: request while busy does not disturb the command in progress
    poke_busy = 1;
    run_row({2'd1, 2'd0, 2'd0, RES_DONE});
    poke_busy = 0;
    // R1: reset in the middle of a command
    send_cmd(2'd0);
    repeat (4) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    check(!busy && cmd_ready && !tx_valid, "R1 reset mid-command",
          int'({busy, cmd_ready, tx_valid}), 3'b010);
    rst = 0;
    run_row({2'd2, 2'd0, 2'd0, RES_DONE});
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule